// File: doc/BRIEF.md
# Timer prescaler and edge selector

This block sits in front of a 16-bit timer/event counter. It supplies the counter with a single-cycle count-enable strobe, and the capture logic with a valid-edge strobe for each of two external timer inputs. An 8-bit mode register chooses where the counter's count events come from. There are four sources: the main clock itself, the main clock divided by 4, the main clock divided by 64, or the valid edge of external input 0. The same register holds a 2-bit edge selector for each external input.

Each external pin passes through a two-flop synchroniser. It is then sampled once every eight main-clock cycles. A new level is accepted only after two consecutive samples agree, which rejects short glitches. The history used to detect edges starts low at reset and advances only while the timer runs. As a result, a pin held high from reset reports one rising edge when the timer is first enabled. A later stop and restart with the pin still high reports nothing. All divided clocks are enable strobes taken from one free-running prescaler counter. No derived clocks are used.

Top module: `tmr_prescale_edge`

## Requirements
- R1: After reset the mode register reads 0x00. Bits 3:2 always read as zero, so a write of 0xFF reads back as 0xF3.
- R2: A mode write takes effect only while `run` is low. A write made while `run` is high leaves the register unchanged.
- R3: Count source field (bits 1:0) code 00 gives `cnt_en` on every cycle. Code 01 gives one strobe in every 4 cycles, and code 10 gives one strobe in every 64 cycles.
- R4: With count source code 11, `cnt_en` is exactly the edge strobe of input 0.
- R5: The edge field for input 1 is bits 7:6 and the edge field for input 0 is bits 5:4. Code 00 selects falling edges, 01 rising edges and 11 both edges. Code 10 never produces an edge strobe.
- R6: An input pulse shorter than 8 clock cycles produces no edge strobe. A pulse of 16 cycles or more is always detected, on both its leading and its trailing edge.
- R7: If a pin is high after reset and rising or both edges are selected, one rising-edge strobe is produced in the first enabled cycle.
- R8: After a stop and a restart, a pin that stayed high produces no edge strobe.
- R9: While `run` is low, `cnt_en`, `edge0` and `edge1` stay low.
- R10: Each edge strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timer enable |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data |
| mode_q | output | 8 | Current mode register value |
| pin0 | input | 1 | External timer input 0 (asynchronous) |
| pin1 | input | 1 | External timer input 1 (asynchronous) |
| cnt_en | output | 1 | Count-enable strobe for the counter |
| edge0 | output | 1 | Valid-edge strobe of input 0 |
| edge1 | output | 1 | Valid-edge strobe of input 1 |

## Verification
Pulses of 1 to 7 and of 16 to 20 cycles are swept across all eight phases of the sampling strobe. Counting the resulting strobes separates the glitch filter's reject band from its guaranteed-accept band. Every edge-select code is tried with one accepted pulse on both pins, so that falling, rising, both and prohibited codes each give a distinct strobe count. The count-source codes are told apart by the number of strobes in a 256-cycle window. A reset with the pins held high, followed by a stop and a restart, separates the power-up rising edge from a spurious edge on re-enable.

// File: rtl/tmr_prescale_edge.sv
module tmr_prescale_edge #(
  parameter int PRE_W   = 6,
  parameter int MID_LOG = 2,
  parameter int SMP_LOG = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] mode_q,
  input  logic       pin0,
  input  logic       pin1,
  output logic       cnt_en,
  output logic       edge0,
  output logic       edge1
);

  logic [PRE_W-1:0] pre;
  logic             tick_mid, tick_slow, tick_smp;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= pre + 1'b1;

  assign tick_mid  = &pre[MID_LOG-1:0];
  assign tick_slow = &pre;
  assign tick_smp  = &pre[SMP_LOG-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             mode_q <= 8'h00;
    else if (cfg_we && !run) mode_q <= {cfg_wdata[7:4], 2'b00, cfg_wdata[1:0]};

  logic [1:0] pin_v, s1, s2, smp, lvl, hist, hit;
  logic [1:0] esel [2];

  assign pin_v   = {pin1, pin0};
  assign esel[0] = mode_q[5:4];
  assign esel[1] = mode_q[7:6];

  for (genvar i = 0; i < 2; i++) begin : g_pin
    logic rise, fall;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        s1[i]   <= 1'b0;
        s2[i]   <= 1'b0;
        smp[i]  <= 1'b0;
        lvl[i]  <= 1'b0;
        hist[i] <= 1'b0;
      end else begin
        s1[i] <= pin_v[i];
        s2[i] <= s1[i];
        if (tick_smp) begin
          smp[i] <= s2[i];
          if (s2[i] == smp[i]) lvl[i] <= s2[i];
        end
        if (run) hist[i] <= lvl[i];
      end

    assign rise   = lvl[i] & ~hist[i];
    assign fall   = ~lvl[i] & hist[i];
    assign hit[i] = run & (((esel[i] == 2'b00) & fall) |
                           ((esel[i] == 2'b01) & rise) |
                           ((esel[i] == 2'b11) & (rise | fall)));
  end

  assign edge0 = hit[0];
  assign edge1 = hit[1];

  always_comb
    case (mode_q[1:0])
      2'b00:   cnt_en = run;
      2'b01:   cnt_en = run & tick_mid;
      2'b10:   cnt_en = run & tick_slow;
      default: cnt_en = hit[0];
    endcase

endmodule

// File: rtl/tmr_prescale_edge_chk.sv
module tmr_prescale_edge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic [7:0] mode_q,
  input logic       cnt_en,
  input logic       edge0,
  input logic       edge1
);

  assert_zero_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[3:2] == 2'b00);

  assert_locked_while_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(mode_q));

  assert_full_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q[1:0] == 2'b00) |-> cnt_en);

  assert_edge_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b11) |-> (cnt_en == edge0));

  assert_prohibited_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q[5:4] == 2'b10) |-> !edge0) and ((mode_q[7:6] == 2'b10) |-> !edge1));

  assert_quiet_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(cnt_en || edge0 || edge1));

  assert_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (edge0 |=> !edge0) and (edge1 |=> !edge1));

endmodule

bind tmr_prescale_edge tmr_prescale_edge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mode_q(mode_q),
  .cnt_en(cnt_en), .edge0(edge0), .edge1(edge1)
);

// File: tb/test_tmr_prescale_edge.sv
`timescale 1ns/1ps
module test_tmr_prescale_edge;
  logic       clk = 0, rst_n = 0, run = 0, cfg_we = 0, pin0 = 0, pin1 = 0;
  logic [7:0] cfg_wdata = 0, mode_q;
  logic       cnt_en, edge0, edge1;
  int         n_cmp = 0, n_bad = 0, c_ce, c_e0, c_e1;
  bit         done = 0;

  always #2.5 clk = ~clk;

  tmr_prescale_edge i_tmr_prescale_edge (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mode_q(mode_q), .pin0(pin0), .pin1(pin1), .cnt_en(cnt_en), .edge0(edge0), .edge1(edge1));

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    c_ce = 0; c_e0 = 0; c_e1 = 0;
  endtask

  task automatic watch(int n);
    for (int k = 0; k < n; k++) begin
      #1;
      c_ce += int'(cnt_en); c_e0 += int'(edge0); c_e1 += int'(edge1);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [7:0] d);
    cfg_we = 1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse(int w);
    watch(40);
    pin0 = 1; pin1 = 1;
    watch(w);
    pin0 = 0; pin1 = 0;
    watch(60);
  endtask

  initial begin
    pin0 = 1; pin1 = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset value", mode_q, 8'h00);
    wr(8'h53);
    chk("R1 write readback", mode_q, 8'h53);
    clr(); watch(40);
    chk("R9 stopped edge0", c_e0, 0);
    run = 1;
    clr(); watch(4);
    chk("R7 power-up rise edge0", c_e0, 1);
    chk("R7 power-up rise edge1", c_e1, 1);
    chk("R4 power-up cnt_en", c_ce, 1);
    run = 0; watch(10); run = 1;
    clr(); watch(20);
    chk("R8 restart edge0", c_e0, 0);
    chk("R8 restart edge1", c_e1, 0);
    pin0 = 0; pin1 = 0; watch(40);

    run = 0; @(negedge clk);
    wr(8'hFF);
    chk("R1 bits 3:2 zero", mode_q, 8'hF3);
    wr(8'hF3);
    clr(); pulse(20);
    chk("R9 stopped cnt_en", c_ce, 0);
    chk("R9 stopped edges", c_e0 + c_e1, 0);

    run = 1; @(negedge clk);
    wr(8'h02);
    chk("R2 write while running", mode_q, 8'hF3);
    run = 0; @(negedge clk);

    for (int m = 0; m < 3; m++) begin
      wr(8'(m));
      run = 1;
      clr(); watch(256);
      chk($sformatf("R3 rate code %0d", m), c_ce, (m == 0) ? 256 : (m == 1) ? 64 : 4);
      run = 0; @(negedge clk);
    end

    for (int c = 0; c < 4; c++) begin
      int exp;
      exp = (c == 2) ? 0 : (c == 3) ? 2 : 1;
      wr(8'((c << 6) | (c << 4) | 3));
      run = 1;
      clr(); pulse(20);
      chk($sformatf("R5 code %0d edge0", c), c_e0, exp);
      chk($sformatf("R5 code %0d edge1", c), c_e1, exp);
      chk($sformatf("R4 code %0d cnt_en", c), c_ce, exp);
      run = 0; @(negedge clk);
    end

    wr(8'hF3);
    run = 1;
    for (int w = 1; w <= 20; w++) begin
      if (w >= 8 && w < 16) continue;
      for (int ph = 0; ph < 8; ph++) begin
        watch(ph);
        clr(); pulse(w);
        chk($sformatf("R6 width %0d phase %0d edge0", w, ph), c_e0, (w < 8) ? 0 : 2);
        chk($sformatf("R6 width %0d phase %0d edge1", w, ph), c_e1, (w < 8) ? 0 : 2);
      end
    end

    clr();
    for (int k = 0; k < 3; k++) begin
      pin0 = ~pin0;
      for (int j = 0; j < 40; j++) begin
        #1;
        if (edge0) begin
          @(negedge clk); #1;
          chk("R10 strobe one cycle", int'(edge0), 0);
        end
        @(negedge clk);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule